// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synchronous memory. Reads and writes can follow each other on every clock with no idle cycle between them. A command (address, direction, byte-lane strobes) is registered on a rising clock edge. The following clock period is that command's data cycle:

- A read presents the addressed word on the output during that same period, with no further register on the path.
- A write takes its data from the input bus at the next enabled rising edge. That edge is the same one that accepts the next command.

One low-active enable qualifies every edge. When it is high, the clock is ignored completely.

A loaded address can be followed by up to three advance beats. A two-bit beat counter changes the low two address bits, either by adding the beat number or by XOR-ing it in. Both forms wrap within an aligned group of four words. The direction chosen when the address is loaded applies to the whole burst.

A write whose data has just arrived is held in a one-entry pending buffer and committed to the array at the next enabled edge. Any read of the same word in the meantime returns the pending bytes merged over the stored word. The data bus is split into input, output and output-enable signals. The enable is high only in a read data cycle while the asynchronous drive control is low. The address width must be at least 2.

Top module: `ztsram_ctrl`

## Requirements
- R1: While `ena_n` is high at a rising edge, nothing changes: command state, burst position, pending write and array contents all keep their values, and `dq_out`/`dq_oe` stay as they were.
- R2: With `ena_n` low and `burst_cont` low, a command is accepted only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination is a deselect.
- R3: An accepted command with `wr_n`=1 is a read. Through the following clock period `dq_out` shows the addressed word and `dq_oe` equals the inverse of `drive_n`, which acts combinationally.
- R4: An accepted command with `wr_n`=0 is a write. Its data is taken from `dq_in` at the next rising edge with `ena_n` low, and that edge also accepts a new command. During the write's data cycle `dq_oe` is 0 whatever `drive_n` is.
- R5: `lane_wr_n[i]`=0 writes bits 8i+7..8i and `lane_wr_n[i]`=1 keeps the old byte. With all four strobes high the write changes nothing.
- R6: After a deselect edge, `dq_oe` is 0 for the whole following cycle.
- R7: At an enabled edge with `burst_cont`=1 after an accepted command, the beat counter advances by one and the direction is kept. The select inputs and `wr_n` are ignored. If the block is deselected, it stays deselected.
- R8: The word address of a beat keeps the upper bits of the loaded address. Its low two bits are (start+beat) mod 4 when `wrap_xor` was 0 at load, or start XOR beat when it was 1. The counter wraps after four beats.
- R9: `lane_wr_n` is sampled again at every advance edge of a write burst, so each beat carries its own byte mask.
- R10: A read of a word whose write data arrived at the previous enabled edge returns that data, merged byte by byte with the stored word, with no idle cycle in between.
- R11: During and after reset, no command or write is pending and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside |
| ena_n | input | 1 | Clock qualifier, active low; high freezes the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_cont | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 selects write, 1 selects read, sampled at load |
| lane_wr_n | input | DW/8 | Byte-lane write strobes, active low |
| wrap_xor | input | 1 | Burst order at load: 0 additive, 1 XOR |
| addr | input | AW | Word address |
| drive_n | input | 1 | Asynchronous output drive control, active low |
| dq_in | input | DW | Write data from the shared bus |
| dq_out | output | DW | Read data toward the shared bus |
| dq_oe | output | 1 | Drive enable for the shared bus |

## Verification
The case that is hardest to reach from the ports is a read that lands on a word while its write is still in the pending buffer with only some byte lanes set. The case is harder still when a frozen clock stretches that window. The stimulus issues a write and, on the very next edge, a read of the same word. This is swept over all sixteen strobe patterns. Holds are placed inside both read and write bursts. A cycle-level model of the commands in the bench checks every cycle's `dq_oe` and read data.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;

  localparam int LANE_W = 8;

  // low two word-address bits for a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       xor_mode);
    return xor_mode ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/ztsram_cmd.sv
module ztsram_cmd
  import ztsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sel,
  input  logic          burst_cont,
  input  logic          wr_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic          wrap_xor,
  input  logic [AW-1:0] addr,
  output logic          act,
  output logic          wr,
  output logic          cap,
  output logic [AW-1:0] cur_addr,
  output logic [NB-1:0] lane_n
);

  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          mode_q, mode_d;
  logic [NB-1:0] bw_q, bw_d;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    bw_d   = bw_q;
    if (!burst_cont) begin
      act_d = sel;
      if (sel) begin
        wr_d   = ~wr_n;
        base_d = addr;
        cnt_d  = 2'd0;
        mode_d = wrap_xor;
        bw_d   = lane_wr_n;
      end
    end else if (act_q) begin
      cnt_d = cnt_q + 2'd1;
      bw_d  = lane_wr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
      mode_q <= 1'b0;
      bw_q   <= '1;
    end else if (en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      bw_q   <= bw_d;
    end
  end

  always_comb begin
    cur_addr      = base_q;
    cur_addr[1:0] = burst_lo(base_q[1:0], cnt_q, mode_q);
  end

  assign act    = act_q;
  assign wr     = wr_q;
  assign lane_n = bw_q;
  assign cap    = en & act_q & wr_q;

  // R1: a frozen edge leaves all command state alone
  a_r1_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({act_q, wr_q, base_q, cnt_q, mode_q, bw_q}));

  // R7: advancing an active burst keeps direction and steps the beat
  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst_cont && act_q) |=> (act_q && $stable(wr_q) && (cnt_q == $past(cnt_q) + 2'd1)));

  // R7: advancing while deselected stays deselected
  a_r7_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst_cont && !act_q) |=> !act_q);

endmodule

// File: rtl/ztsram_store.sv
module ztsram_store
  import ztsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cap,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW/LANE_W-1:0] lane_n,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rdata
);

  localparam int NB    = DW / LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [NB-1:0] pend_m;
  logic [DW-1:0] pend_d;

  // pending buffer: filled at the data edge, committed at the next enabled edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_m <= '0;
      pend_d <= '0;
    end else if (en) begin
      pend_v <= cap;
      if (cap) begin
        pend_a <= wr_addr;
        pend_m <= ~lane_n;
        pend_d <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && pend_v) begin
      for (int b = 0; b < NB; b++) begin
        if (pend_m[b]) mem[pend_a][b*LANE_W +: LANE_W] <= pend_d[b*LANE_W +: LANE_W];
      end
    end
  end

  // flow-through read with pending-write merge
  always_comb begin
    rdata = mem[rd_addr];
    if (pend_v && (pend_a == rd_addr)) begin
      for (int b = 0; b < NB; b++) begin
        if (pend_m[b]) rdata[b*LANE_W +: LANE_W] = pend_d[b*LANE_W +: LANE_W];
      end
    end
  end

  // R10: the pending entry lives exactly one enabled edge unless refilled
  a_r10_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend_v && !cap) |=> !pend_v);

  // R1: a frozen edge keeps the pending entry
  a_r1_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({pend_v, pend_a, pend_m, pend_d}));

endmodule

// File: rtl/ztsram_ctrl.sv
module ztsram_ctrl
  import ztsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ena_n,
  input  logic                 sel0_n,
  input  logic                 sel1,
  input  logic                 sel2_n,
  input  logic                 burst_cont,
  input  logic                 wr_n,
  input  logic [DW/8-1:0]      lane_wr_n,
  input  logic                 wrap_xor,
  input  logic [AW-1:0]        addr,
  input  logic                 drive_n,
  input  logic [DW-1:0]        dq_in,
  output logic [DW-1:0]        dq_out,
  output logic                 dq_oe
);

  localparam int NB = DW / LANE_W;

  logic rst_meta_n, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic          en, sel;
  logic          act, wr, cap;
  logic [AW-1:0] cur_addr;
  logic [NB-1:0] lane_n;

  assign en  = ~ena_n;
  assign sel = ~sel0_n & sel1 & ~sel2_n;

  ztsram_cmd #(.AW(AW), .NB(NB)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (en),
    .sel        (sel),
    .burst_cont (burst_cont),
    .wr_n       (wr_n),
    .lane_wr_n  (lane_wr_n),
    .wrap_xor   (wrap_xor),
    .addr       (addr),
    .act        (act),
    .wr         (wr),
    .cap        (cap),
    .cur_addr   (cur_addr),
    .lane_n     (lane_n)
  );

  ztsram_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (en),
    .cap     (cap),
    .wr_addr (cur_addr),
    .lane_n  (lane_n),
    .wdata   (dq_in),
    .rd_addr (cur_addr),
    .rdata   (dq_out)
  );

  assign dq_oe = act & ~wr & ~drive_n;

  // R4: the data cycle of a freshly loaded write never drives the bus
  a_r4_write_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && sel && !burst_cont && !wr_n) |=> !dq_oe);

  // R6: a deselect edge turns the drivers off for the next cycle
  a_r6_deselect_off: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && !sel && !burst_cont) |=> !dq_oe);

  // R3: a loaded read drives exactly when drive_n is low
  a_r3_read_drive: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && sel && !burst_cont && wr_n) |=> (dq_oe == !drive_n));

  // R11: no drive while held in reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_core_n |-> !dq_oe);

endmodule

// File: tb/ztsram_ctrl_test.sv
`timescale 1ns/1ps
module ztsram_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, ena_n, sel0_n, sel1, sel2_n, burst_cont, wr_n, wrap_xor, drive_n;
  logic [NB-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  ztsram_ctrl #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ena_n(ena_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .wrap_xor(wrap_xor),
    .addr(addr), .drive_n(drive_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // reference model built from the requirements
  logic [DW-1:0] ref_mem [DEPTH];
  logic          m_act, m_wr, m_mode;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic [NB-1:0] m_bw;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R11";
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  function automatic logic [AW-1:0] m_addr();
    logic [AW-1:0] a;
    a = m_base;
    a[1:0] = m_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt); // R8
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick();
    logic sel_m, exp_oe;
    logic [AW-1:0] a;
    seed = seed * 32'd1103515245 + 32'd12345;
    dq_in = seed;
    @(posedge clk);
    if (!ena_n) begin
      if (m_act && m_wr) begin
        a = m_addr();
        for (int b = 0; b < NB; b++)
          if (!m_bw[b]) ref_mem[a][b*8 +: 8] = dq_in[b*8 +: 8]; // R5
      end
      sel_m = !sel0_n && sel1 && !sel2_n; // R2
      if (!burst_cont) begin
        m_act = sel_m;
        if (sel_m) begin
          m_wr = !wr_n; m_base = addr; m_cnt = 2'd0; m_mode = wrap_xor; m_bw = lane_wr_n;
        end
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1; m_bw = lane_wr_n; // R7 R9
      end
    end
    @(negedge clk);
    exp_oe = m_act && !m_wr && !drive_n;
    chk(dq_oe === exp_oe, !m_act ? "R6" : (m_wr ? "R4" : "R3"), {31'd0, dq_oe}, {31'd0, exp_oe});
    if (exp_oe) chk(dq_out === ref_mem[m_addr()], tag, dq_out, ref_mem[m_addr()]);
  endtask

  task automatic drv(input logic en_n, input logic [2:0] c, input logic bc, input logic w_n,
                     input logic [NB-1:0] ln, input logic [AW-1:0] a, input logic xm);
    ena_n = en_n; sel0_n = c[0]; sel1 = c[1]; sel2_n = c[2];
    burst_cont = bc; wr_n = w_n; lane_wr_n = ln; addr = a; wrap_xor = xm;
    tick();
  endtask

  task automatic ld(input logic w, input logic [AW-1:0] a, input logic [NB-1:0] ln, input logic xm);
    drv(1'b0, 3'b010, 1'b0, ~w, ln, a, xm);
  endtask

  task automatic adv(input logic [NB-1:0] ln);
    drv(1'b0, 3'b101, 1'b1, 1'b0, ln, '0, 1'b0);
  endtask

  task automatic idle();
    drv(1'b0, 3'b000, 1'b0, 1'b1, 4'hF, '0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    m_act = 0; m_wr = 0; m_mode = 0; m_base = '0; m_cnt = '0; m_bw = '1;
    rst_n = 0; ena_n = 0; sel0_n = 0; sel1 = 0; sel2_n = 0; burst_cont = 0;
    wr_n = 1; lane_wr_n = 4'hF; addr = '0; wrap_xor = 0; drive_n = 0; dq_in = '0;
    repeat (3) @(negedge clk);
    chk(dq_oe === 1'b0, "R11", {31'd0, dq_oe}, 32'd0);
    rst_n = 1;
    repeat (4) idle();
    chk(dq_oe === 1'b0, "R11", {31'd0, dq_oe}, 32'd0);

    // fill all words with bursts of full-mask writes
    tag = "R4";
    for (int g = 0; g < DEPTH / 4; g++) begin
      ld(1'b1, AW'(g * 4), 4'h0, 1'b0);
      repeat (3) adv(4'h0);
    end
    idle();

    // R8 R7: read bursts from every start in both orders
    tag = "R8";
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < DEPTH; a++) begin
        ld(1'b0, AW'(a), 4'hF, m[0]);
        repeat (3) adv(4'hF);
        adv(4'hF); // fifth beat wraps to the start word
      end

    // R2: every select combination on a load
    tag = "R2";
    for (int c = 0; c < 8; c++) begin
      drv(1'b0, c[2:0], 1'b0, 1'b1, 4'hF, AW'(c), 1'b0);
      drv(1'b0, 3'b010, 1'b1, 1'b1, 4'hF, '0, 1'b0); // R7: advance ignores selects
    end

    // R5 R10: write then immediate read of the same word, all strobe patterns
    tag = "R10";
    for (int p = 0; p < 16; p++) begin
      ld(1'b1, AW'(p), p[3:0], 1'b0);
      ld(1'b0, AW'(p), 4'hF, 1'b0);
    end
    idle();
    tag = "R5";
    for (int p = 0; p < 16; p++) ld(1'b0, AW'(p), 4'hF, 1'b0);

    // R4: alternating write and read every cycle, drive_n low through writes
    tag = "R4";
    for (int i = 0; i < 32; i++) begin
      ld(1'b1, AW'(i * 5), AW'(i), i[0]);
      ld(1'b0, AW'(i * 3), 4'hF, i[1]);
    end

    // R9: write burst with a new mask each beat in XOR order, then read it back
    tag = "R9";
    ld(1'b1, AW'(5), 4'b1110, 1'b1);
    adv(4'b1101); adv(4'b1011); adv(4'b0111);
    ld(1'b0, AW'(5), 4'hF, 1'b1);
    repeat (3) adv(4'hF);

    // R1: hold during a read burst
    tag = "R1";
    ld(1'b0, AW'(8), 4'hF, 1'b0);
    held = dq_out;
    drv(1'b1, 3'b000, 1'b0, 1'b0, 4'h0, '0, 1'b1);
    drv(1'b1, 3'b111, 1'b1, 1'b0, 4'h0, '0, 1'b1);
    chk(dq_out === held && dq_oe === 1'b1, "R1", dq_out, held);
    adv(4'hF);
    // R1: hold during a write data cycle, then read it back
    ld(1'b1, AW'(9), 4'h0, 1'b0);
    drv(1'b1, 3'b000, 1'b0, 1'b1, 4'hF, '0, 1'b0);
    drv(1'b1, 3'b000, 1'b0, 1'b1, 4'hF, '0, 1'b0);
    ld(1'b0, AW'(9), 4'hF, 1'b0);
    drv(1'b1, 3'b000, 1'b0, 1'b1, 4'hF, '0, 1'b0); // read of a pending word under hold

    // R3: drive_n acts without a clock edge
    tag = "R3";
    ld(1'b0, AW'(3), 4'hF, 1'b0);
    drive_n = 1; #1;
    chk(dq_oe === 1'b0, "R3", {31'd0, dq_oe}, 32'd0);
    drive_n = 0; #1;
    chk(dq_oe === 1'b1 && dq_out === ref_mem[3], "R3", dq_out, ref_mem[3]);

    // R6 R7: deselect, then advance with selects active stays off
    tag = "R6";
    idle();
    drv(1'b0, 3'b010, 1'b1, 1'b1, 4'hF, AW'(2), 1'b0);
    chk(dq_oe === 1'b0, "R7", {31'd0, dq_oe}, 32'd0);
    idle();

    done = 1;
    summary();
    $finish;
  end
endmodule